// File: doc/BRIEF.md
# Egress Order-Tracking Scheduler

This block is the controller of a single output port in a two-stage packet switch. The switch has N middle nodes between its two fabrics. Every slot, each middle node reports whether it has just buffered a packet for this output, and whether that packet is a reservation packet or a contention packet. The first fabric connects inputs to middle nodes in a fixed rotating pattern, so the block can work out which input sent each packet. It keeps one in-order queue per input. Each queue entry records the packet kind, the middle node holding the packet, and the slot timestamp of its arrival.

The queues are used to keep every flow in order. The output asks a middle node for a contention packet only when that packet is the oldest buffered packet of its flow. The output accepts a reservation frame only when the frame's first packet, which sits at middle node 0, is the oldest packet of its flow. On a grant from the external matcher, the block picks one qualifying queue in round-robin order. It returns the low timestamp bits to the middle node so the node can find the packet in its slot-indexed buffer. It also raises a global stall bit when a reservation packet is queued behind a contention packet of the same flow.

Top module: `egress_order_sched`

## Requirements
- R1: A report valid at middle node r in slot t (t counted from 0 in the first cycle after reset release) is appended to the queue of input (r − t) mod N. The entry holds the kind (1 = reservation), the node r, and timestamp t.
- R2: Request bit r is 1 exactly when some queue's head is a contention entry held at node r and the port is not receiving a reservation packet in that slot.
- R3: A frame can start only in a slot with (t + OUT_IDX) mod N = 0. It starts only if the oldest unstarted reservation frame, recorded when a reservation report arrives at node 0, has its source queue's head as a reservation entry at node 0. Otherwise no frame starts and `resRecv` stays 0.
- R4: A started frame holds `resRecv` at 1 for N consecutive slots, with `resNode` counting 0, 1, …, N−1. Each of those slots pops the head of the frame's source queue.
- R5: When `grant` (one-hot, bit r = node r) names a node with a pending request, the block picks one queue whose head is a contention entry at that node. The search starts at the round-robin pointer and wraps; the pointer is 0 after reset and moves to one past the pick. The block asserts `conValid`, drives the low log2 W timestamp bits on `conTs`, and pops that head.
- R6: After a pop, the next entry of that queue becomes visible as its head in the following slot.
- R7: `globalBlock` is 1 exactly when some queue holds a reservation entry while its head is not a reservation entry.
- R8: A report whose queue already holds DEPTH entries is dropped. `overflow` becomes 1 in the next slot and stays 1 until reset.
- R9: During and right after reset, all queues are empty, `request` is 0, `resRecv` is 0, `conValid` is 0, `globalBlock` is 0 and `overflow` is 0.
- R10: A grant for a node that no queue head qualifies for leaves `conValid` at 0 and pops nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rstN | input | 1 | Asynchronous active-low reset |
| arrValid | input | N | Per middle node: a packet for this output was buffered this slot |
| arrRes | input | N | Per middle node: that packet is a reservation packet |
| grant | input | N | One-hot grant from the matcher, bit r = middle node r |
| request | output | N | Contention request, bit r = middle node r |
| conValid | output | 1 | A granted contention packet was selected this slot |
| conTs | output | log2 W | Low timestamp bits of the selected packet |
| resRecv | output | 1 | A reservation packet is being received this slot |
| resNode | output | log2 N | Middle node the reservation packet comes from |
| globalBlock | output | 1 | Stall request for contention sending at the inputs |
| overflow | output | 1 | Sticky: a report was dropped on a full queue |

## Verification
The bench builds the block with N = 4, W = 8, DEPTH = 4, an 8-bit timestamp and OUT_IDX = 1. With these values, check slots fall at t = 3, 7, 11, so a non-zero port offset is exercised. A queue fills in four slots, so the dropped fifth report and the sticky flag are reached quickly. The 3-bit timestamp slice shows directly that the returned value is the arrival slot. Four nodes are enough for three heads at one node, which makes the round-robin wrap differ from oldest-first order. A reservation queued behind a contention packet shows both the stall bit and a check slot that refuses a frame.

// File: rtl/eos_pkg.sv
package eos_pkg;

  typedef enum logic {
    KIND_CON = 1'b0,
    KIND_RES = 1'b1
  } pktKind_e;

  // pop strobes issued by the control to the queue bank
  typedef struct packed {
    logic resPop;
    logic conPop;
  } popStrobe_t;

endpackage

// File: rtl/eos_ifq_bank.sv
module eos_ifq_bank
  import eos_pkg::*;
#(
  parameter int N     = 4,
  parameter int DEPTH = 4,
  parameter int TS_W  = 8,
  localparam int NW   = $clog2(N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [N-1:0]      arrValid,
  input  logic [N-1:0]      arrRes,
  input  logic [NW-1:0]     slotPhase,
  input  logic [TS_W-1:0]   tsNow,
  input  popStrobe_t        strobe,
  input  logic [NW-1:0]     resSrc,
  input  logic [NW-1:0]     conSel,
  output logic [N-1:0]      headValid,
  output logic [N-1:0]      headRes,
  output logic [N-1:0]      hasRes,
  output logic [NW-1:0]     headNode [N],
  output logic [TS_W-1:0]   headTs [N],
  output logic              overflow
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [N-1:0] ovfHit;

  for (genvar i = 0; i < N; i++) begin : g_ifq
    pktKind_e          memKind [DEPTH];
    logic [NW-1:0]     memNode [DEPTH];
    logic [TS_W-1:0]   memTs   [DEPTH];
    logic [PW-1:0]     rdPtr, wrPtr;
    logic [CW-1:0]     count, resCnt;
    logic [NW-1:0]     srcNode;
    logic              push, pushRes, pop, accept, popIsRes;

    // the node that input i is wired to in this slot
    always_comb begin
      int s;
      s = i + int'(slotPhase);
      if (s >= N) s = s - N;
      srcNode = NW'(s);
    end

    assign push     = arrValid[srcNode];
    assign pushRes  = arrRes[srcNode];
    assign accept   = push && (count != CW'(DEPTH));
    assign ovfHit[i] = push && !accept;
    assign pop      = (count != '0) &&
                      ((strobe.resPop && resSrc == NW'(i)) ||
                       (strobe.conPop && conSel == NW'(i)));
    assign popIsRes = pop && (memKind[rdPtr] == KIND_RES);

    always_ff @(posedge clk) begin
      if (accept) begin
        memKind[wrPtr] <= pushRes ? KIND_RES : KIND_CON;
        memNode[wrPtr] <= srcNode;
        memTs[wrPtr]   <= tsNow;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rdPtr  <= '0;
        wrPtr  <= '0;
        count  <= '0;
        resCnt <= '0;
      end else begin
        if (accept) wrPtr <= (wrPtr == PW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
        if (pop)    rdPtr <= (rdPtr == PW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
        count  <= count + CW'(accept) - CW'(pop);
        resCnt <= resCnt + CW'(accept && pushRes) - CW'(popIsRes);
      end
    end

    assign headValid[i] = (count != '0);
    assign headRes[i]   = (memKind[rdPtr] == KIND_RES);
    assign headNode[i]  = memNode[rdPtr];
    assign headTs[i]    = memTs[rdPtr];
    assign hasRes[i]    = (resCnt != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            overflow <= 1'b0;
    else if (|ovfHit)     overflow <= 1'b1;
  end

endmodule

// File: rtl/eos_ctl.sv
module eos_ctl
  import eos_pkg::*;
#(
  parameter int N       = 4,
  parameter int W       = 8,
  parameter int TS_W    = 8,
  parameter int OUT_IDX = 1,
  parameter int FDEPTH  = 4,
  localparam int NW     = $clog2(N),
  localparam int WB     = $clog2(W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [N-1:0]      arrValid,
  input  logic [N-1:0]      arrRes,
  input  logic [N-1:0]      grant,
  input  logic [N-1:0]      headValid,
  input  logic [N-1:0]      headRes,
  input  logic [N-1:0]      hasRes,
  input  logic [NW-1:0]     headNode [N],
  input  logic [TS_W-1:0]   headTs [N],
  output logic [NW-1:0]     slotPhase,
  output logic [TS_W-1:0]   tsNow,
  output popStrobe_t        strobe,
  output logic [NW-1:0]     resSrc,
  output logic [NW-1:0]     conSel,
  output logic [N-1:0]      request,
  output logic              conValid,
  output logic [WB-1:0]     conTs,
  output logic              resRecv,
  output logic [NW-1:0]     resNode,
  output logic              globalBlock
);

  localparam int FPW = (FDEPTH > 1) ? $clog2(FDEPTH) : 1;
  localparam int FCW = $clog2(FDEPTH + 1);
  localparam int OFS = OUT_IDX % N;

  // slot counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotPhase <= '0;
      tsNow     <= '0;
    end else begin
      slotPhase <= (slotPhase == NW'(N - 1)) ? '0 : slotPhase + 1'b1;
      tsNow     <= tsNow + 1'b1;
    end
  end

  logic checkSlot;
  logic [NW-1:0] node0Src;
  always_comb begin
    int c;
    int s;
    c = int'(slotPhase) + OFS;
    if (c >= N) c = c - N;
    checkSlot = (c == 0);
    s = N - int'(slotPhase);
    if (s == N) s = 0;
    node0Src = NW'(s);
  end

  // order of reservation frames planted at node 0
  logic [NW-1:0]  fMem [FDEPTH];
  logic [FPW-1:0] fRd, fWr;
  logic [FCW-1:0] fCount;
  logic [NW-1:0]  front;
  logic           fPush, frameStart;
  logic           frameOn;
  logic [NW-1:0]  frameNode, frameSrc;

  assign front = fMem[fRd];
  assign fPush = arrValid[0] && arrRes[0] && (fCount != FCW'(FDEPTH));
  assign frameStart = checkSlot && !frameOn && (fCount != '0) &&
                      headValid[front] && headRes[front] &&
                      (headNode[front] == '0);

  always_ff @(posedge clk) begin
    if (fPush) fMem[fWr] <= node0Src;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fRd       <= '0;
      fWr       <= '0;
      fCount    <= '0;
      frameOn   <= 1'b0;
      frameNode <= '0;
      frameSrc  <= '0;
    end else begin
      if (fPush)      fWr <= (fWr == FPW'(FDEPTH - 1)) ? '0 : fWr + 1'b1;
      if (frameStart) fRd <= (fRd == FPW'(FDEPTH - 1)) ? '0 : fRd + 1'b1;
      fCount <= fCount + FCW'(fPush) - FCW'(frameStart);
      if (frameStart) begin
        frameOn   <= 1'b1;
        frameNode <= NW'(1);
        frameSrc  <= front;
      end else if (frameOn) begin
        if (frameNode == NW'(N - 1)) frameOn <= 1'b0;
        frameNode <= frameNode + 1'b1;
      end
    end
  end

  assign resRecv = frameStart || frameOn;
  assign resNode = frameOn ? frameNode : '0;
  assign resSrc  = frameOn ? frameSrc : front;

  // contention requests and grant selection
  logic [N-1:0]  conHead, cand;
  logic [NW-1:0] gIdx, rrPtr;
  logic          gHit;

  always_comb begin
    request = '0;
    gIdx    = '0;
    for (int i = 0; i < N; i++) begin
      conHead[i] = headValid[i] && !headRes[i];
      if (!resRecv && conHead[i]) request[headNode[i]] = 1'b1;
    end
    for (int r = N - 1; r >= 0; r--) begin
      if (grant[r]) gIdx = NW'(r);
    end
  end

  assign gHit = |grant;

  always_comb begin
    conValid = 1'b0;
    conSel   = '0;
    for (int i = 0; i < N; i++) begin
      cand[i] = gHit && !resRecv && conHead[i] && (headNode[i] == gIdx);
    end
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = int'(rrPtr) + k;
      if (idx >= N) idx = idx - N;
      if (!conValid && cand[idx]) begin
        conValid = 1'b1;
        conSel   = NW'(idx);
      end
    end
  end

  assign conTs = headTs[conSel][WB-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         rrPtr <= '0;
    else if (conValid) rrPtr <= (conSel == NW'(N - 1)) ? '0 : conSel + 1'b1;
  end

  always_comb begin
    globalBlock = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (hasRes[i] && !(headValid[i] && headRes[i])) globalBlock = 1'b1;
    end
  end

  assign strobe.resPop = resRecv;
  assign strobe.conPop = conValid;

endmodule

// File: rtl/egress_order_sched.sv
module egress_order_sched
  import eos_pkg::*;
#(
  parameter int N       = 4,
  parameter int W       = 8,
  parameter int DEPTH   = 4,
  parameter int TS_W    = 8,
  parameter int OUT_IDX = 1,
  localparam int NW     = $clog2(N),
  localparam int WB     = $clog2(W)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [N-1:0]  arrValid,
  input  logic [N-1:0]  arrRes,
  input  logic [N-1:0]  grant,
  output logic [N-1:0]  request,
  output logic          conValid,
  output logic [WB-1:0] conTs,
  output logic          resRecv,
  output logic [NW-1:0] resNode,
  output logic          globalBlock,
  output logic          overflow
);

  logic [N-1:0]    headValid, headRes, hasRes;
  logic [NW-1:0]   headNode [N];
  logic [TS_W-1:0] headTs [N];
  logic [NW-1:0]   slotPhase, resSrc, conSel;
  logic [TS_W-1:0] tsNow;
  popStrobe_t      strobe;

  eos_ctl #(
    .N(N), .W(W), .TS_W(TS_W), .OUT_IDX(OUT_IDX), .FDEPTH(DEPTH)
  ) u_ctl (
    .clk(clk), .rstN(rstN),
    .arrValid(arrValid), .arrRes(arrRes), .grant(grant),
    .headValid(headValid), .headRes(headRes), .hasRes(hasRes),
    .headNode(headNode), .headTs(headTs),
    .slotPhase(slotPhase), .tsNow(tsNow), .strobe(strobe),
    .resSrc(resSrc), .conSel(conSel),
    .request(request), .conValid(conValid), .conTs(conTs),
    .resRecv(resRecv), .resNode(resNode), .globalBlock(globalBlock)
  );

  eos_ifq_bank #(
    .N(N), .DEPTH(DEPTH), .TS_W(TS_W)
  ) u_bank (
    .clk(clk), .rstN(rstN),
    .arrValid(arrValid), .arrRes(arrRes),
    .slotPhase(slotPhase), .tsNow(tsNow), .strobe(strobe),
    .resSrc(resSrc), .conSel(conSel),
    .headValid(headValid), .headRes(headRes), .hasRes(hasRes),
    .headNode(headNode), .headTs(headTs),
    .overflow(overflow)
  );

endmodule

// File: rtl/egress_order_sched_chk.sv
module egress_order_sched_chk #(
  parameter int N       = 4,
  parameter int OUT_IDX = 1,
  localparam int NW     = $clog2(N)
) (
  input logic          clk,
  input logic          rstN,
  input logic [N-1:0]  grant,
  input logic [N-1:0]  request,
  input logic          conValid,
  input logic          resRecv,
  input logic [NW-1:0] resNode,
  input logic          overflow
);

  logic [NW-1:0] chkPhase;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chkPhase <= '0;
    else       chkPhase <= (chkPhase == NW'(N - 1)) ? '0 : chkPhase + 1'b1;
  end

  p_no_req_in_frame_r2: assert property (@(posedge clk) disable iff (!rstN)
    resRecv |-> (request == '0));

  p_frame_at_check_r3: assert property (@(posedge clk) disable iff (!rstN)
    (resRecv && resNode == '0) |-> (((int'(chkPhase) + OUT_IDX % N) % N) == 0));

  p_frame_ascend_r4: assert property (@(posedge clk) disable iff (!rstN)
    (resRecv && resNode != NW'(N - 1)) |=>
      (resRecv && resNode == NW'($past(resNode) + 1'b1)));

  p_grant_backed_r5: assert property (@(posedge clk) disable iff (!rstN)
    conValid |-> ((grant & request) != '0));

  p_overflow_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

endmodule

bind egress_order_sched egress_order_sched_chk #(.N(N), .OUT_IDX(OUT_IDX)) u_chk (
  .clk(clk), .rstN(rstN), .grant(grant), .request(request),
  .conValid(conValid), .resRecv(resRecv), .resNode(resNode),
  .overflow(overflow)
);

// File: tb/egress_order_sched_tb.sv
module egress_order_sched_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N = 4, W = 8, DEPTH = 4, TS_W = 8, OUT_IDX = 1;
  localparam int NROWS = 13;

  // row: arrValid[23:20] arrRes[19:16] grant[15:12] expReq[11:8]
  //      expRes[7] expNode[6:5] expCon[4] expTs[3:1] expGb[0]
  localparam logic [23:0] TBL [NROWS] = '{
    {4'b0100, 4'b0000, 4'b0000, 4'b0000, 1'b0, 2'd0, 1'b0, 3'd0, 1'b0}, // t0
    {4'b0000, 4'b0000, 4'b0000, 4'b0100, 1'b0, 2'd0, 1'b0, 3'd0, 1'b0}, // t1
    {4'b0010, 4'b0000, 4'b0000, 4'b0100, 1'b0, 2'd0, 1'b0, 3'd0, 1'b0}, // t2
    {4'b0000, 4'b0000, 4'b0100, 4'b0110, 1'b0, 2'd0, 1'b1, 3'd0, 1'b0}, // t3
    {4'b0001, 4'b0001, 4'b0000, 4'b0010, 1'b0, 2'd0, 1'b0, 3'd0, 1'b0}, // t4
    {4'b0010, 4'b0010, 4'b0000, 4'b0010, 1'b0, 2'd0, 1'b0, 3'd0, 1'b0}, // t5
    {4'b0100, 4'b0100, 4'b0000, 4'b0010, 1'b0, 2'd0, 1'b0, 3'd0, 1'b0}, // t6
    {4'b1000, 4'b1000, 4'b0000, 4'b0000, 1'b1, 2'd0, 1'b0, 3'd0, 1'b0}, // t7
    {4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd1, 1'b0, 3'd0, 1'b0}, // t8
    {4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd2, 1'b0, 3'd0, 1'b0}, // t9
    {4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd3, 1'b0, 3'd0, 1'b0}, // t10
    {4'b0000, 4'b0000, 4'b0010, 4'b0010, 1'b0, 2'd0, 1'b1, 3'd2, 1'b0}, // t11
    {4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0, 2'd0, 1'b0, 3'd0, 1'b0}  // t12
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] arrValid = '0, arrRes = '0, grant = '0;
  logic [N-1:0] request;
  logic         conValid, resRecv, globalBlock, overflow;
  logic [2:0]   conTs;
  logic [1:0]   resNode;

  int nChk = 0, nFail = 0;
  bit done = 1'b0;

  egress_order_sched #(
    .N(N), .W(W), .DEPTH(DEPTH), .TS_W(TS_W), .OUT_IDX(OUT_IDX)
  ) u_dut (
    .clk(clk), .rstN(rstN), .arrValid(arrValid), .arrRes(arrRes),
    .grant(grant), .request(request), .conValid(conValid), .conTs(conTs),
    .resRecv(resRecv), .resNode(resNode), .globalBlock(globalBlock),
    .overflow(overflow)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // at a falling edge: drive a slot's inputs and let outputs settle
  task automatic slot(input logic [3:0] v, input logic [3:0] r, input logic [3:0] g);
    arrValid = v;
    arrRes   = r;
    grant    = g;
    #1;
  endtask

  task automatic adv();
    @(posedge clk);
    @(negedge clk);
    arrValid = '0;
    arrRes   = '0;
    grant    = '0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    arrValid = '0;
    arrRes = '0;
    grant = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    // R9 reset state
    repeat (2) @(negedge clk);
    #1;
    check("R9 request", int'(request), 0);
    check("R9 resRecv", int'(resRecv), 0);
    check("R9 conValid", int'(conValid), 0);
    check("R9 globalBlock", int'(globalBlock), 0);
    check("R9 overflow", int'(overflow), 0);

    // vector table: R1 mapping, R2 requests, R3/R4 frame, R5 grant, R6 next head
    doReset();
    for (int k = 0; k < NROWS; k++) begin
      logic [23:0] row;
      row = TBL[k];
      slot(row[23:20], row[19:16], row[15:12]);
      check($sformatf("R2 R1 request t%0d", k), int'(request), int'(row[11:8]));
      check($sformatf("R3 resRecv t%0d", k), int'(resRecv), int'(row[7]));
      if (row[7]) check($sformatf("R4 resNode t%0d", k), int'(resNode), int'(row[6:5]));
      check($sformatf("R5 conValid t%0d", k), int'(conValid), int'(row[4]));
      if (row[4]) check($sformatf("R5 R1 conTs t%0d", k), int'(conTs), int'(row[3:1]));
      check($sformatf("R7 globalBlock t%0d", k), int'(globalBlock), int'(row[0]));
      adv();
    end

    // R7 stall bit and R3 refused frame: reservation behind contention in queue 0
    doReset();
    slot(4'b0001, 4'b0000, 4'b0000); adv();           // t0 contention, queue 0
    repeat (3) adv();                                  // t1..t3
    slot(4'b0001, 4'b0001, 4'b0000); adv();           // t4 reservation, queue 0
    slot(4'b0000, 4'b0000, 4'b0000);                  // t5
    check("R7 block raised", int'(globalBlock), 1);
    check("R2 request head node0", int'(request), 1);
    adv();
    adv();                                             // t6
    slot(4'b0000, 4'b0000, 4'b0001);                  // t7 check slot
    check("R3 frame refused", int'(resRecv), 0);
    check("R5 grant node0", int'(conValid), 1);
    check("R5 conTs", int'(conTs), 0);
    adv();
    slot(4'b0000, 4'b0000, 4'b0000);                  // t8
    check("R7 block cleared", int'(globalBlock), 0);
    check("R6 head now reservation", int'(request), 0);
    adv();
    adv();                                             // t9
    adv();                                             // t10
    slot(4'b0000, 4'b0000, 4'b0000);                  // t11 check slot
    check("R3 frame starts", int'(resRecv), 1);
    check("R4 first node", int'(resNode), 0);
    adv();

    // R5 round-robin order and R10 stray grant
    doReset();
    slot(4'b0010, 4'b0000, 4'b0000); adv();           // t0 -> queue 1 ts0
    slot(4'b0010, 4'b0000, 4'b0000); adv();           // t1 -> queue 0 ts1
    slot(4'b0010, 4'b0000, 4'b0010);                  // t2 -> queue 3 ts2
    check("R5 rr pick q0", int'(conValid), 1);
    check("R5 rr ts q0", int'(conTs), 1);
    adv();
    slot(4'b0000, 4'b0000, 4'b0010);                  // t3
    check("R5 rr pick q1", int'(conValid), 1);
    check("R5 rr ts q1", int'(conTs), 0);
    adv();
    slot(4'b0000, 4'b0000, 4'b0010);                  // t4
    check("R5 rr pick q3", int'(conValid), 1);
    check("R5 rr ts q3", int'(conTs), 2);
    adv();
    slot(4'b0000, 4'b0000, 4'b0010);                  // t5
    check("R10 stray grant", int'(conValid), 0);
    check("R10 request empty", int'(request), 0);
    adv();

    // R8 overflow: five reports for queue 0 with DEPTH 4
    doReset();
    for (int t = 0; t < 5; t++) begin
      slot(4'(1 << (t % 4)), 4'b0000, 4'b0000);
      if (t == 4) check("R8 overflow not yet", int'(overflow), 0);
      adv();
    end
    for (int t = 5; t < 9; t++) begin
      slot(4'b0000, 4'b0000, 4'(1 << (t - 5)));
      check($sformatf("R8 overflow t%0d", t), int'(overflow), 1);
      check($sformatf("R6 request t%0d", t), int'(request), 1 << (t - 5));
      check($sformatf("R6 conTs t%0d", t), int'(conTs), t - 5);
      adv();
    end
    slot(4'b0000, 4'b0000, 4'b0000);
    check("R8 dropped entry absent", int'(request), 0);
    check("R8 overflow held", int'(overflow), 1);
    adv();

    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule